// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a processor that shares one ALU and one memory across several clock cycles per instruction. Each instruction passes through a chain of steps. The chain always starts with a fetch step and a decode step. After decode, the path depends on the instruction class held in the instruction register. The sequencer is a Moore machine: every control line that the datapath sees is a function of the current step only. The opcode is used only to choose the next step.

The sequencer has ten steps. Fetch reads the instruction and advances the program counter by four. Decode reads the register operands and precomputes a branch target. After these two steps, the chain splits by class:

- Load uses address compute, memory read and register write-back.
- Store uses address compute and memory write.
- Register-to-register ALU operations use an execute step and a register write step.
- Branch-if-equal uses one conditional PC update step.
- Jump uses one unconditional PC update step.

Every chain returns to fetch when it ends. An opcode outside these classes goes from decode straight back to fetch.

The datapath places the 6-bit opcode field of the instruction register on `opcode`. It then obeys the control lines on every rising clock edge.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the fetch pattern is driven: `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `alu_b_sel`=01. Every other output is 0, including `alu_a_sel`, `addr_sel_data`, `pc_src`=00 and `alu_op`=00.
- R2: A fetch step is always followed by a decode step. Decode drives `alu_b_sel`=11, `alu_a_sel`=0 and `alu_op`=00 (add), and every other output is 0.
- R3: After decode, the next step is chosen from the opcode. Opcodes 100011 (load) and 101011 (store) go to address compute, which drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00. Opcode 000000 goes to ALU execute, 000100 goes to the branch step and 000010 goes to the jump step.
- R4: For a load, address compute is followed by a read step: `mem_rd`=1 and `addr_sel_data`=1. The read step is followed by a write-back step: `reg_wr`=1, `wb_from_mem`=1 and `dst_sel_rd`=0. A load takes 5 cycles, from fetch to the next fetch.
- R5: For a store, address compute is followed by a write step: `mem_wr`=1 and `addr_sel_data`=1. A store takes 4 cycles.
- R6: For an ALU operation, the execute step drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10 (function field decides). It is followed by a write step: `reg_wr`=1, `dst_sel_rd`=1 and `wb_from_mem`=0. An ALU operation takes 4 cycles.
- R7: The branch step drives `pc_wr_cond`=1, `pc_src`=01, `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=01 (subtract), with `pc_wr`=0. A branch takes 3 cycles.
- R8: The jump step drives `pc_wr`=1 and `pc_src`=10, and every other output is 0. A jump takes 3 cycles.
- R9: Any other opcode returns from decode straight to fetch. It takes 2 cycles and asserts neither `mem_wr` nor `reg_wr`.
- R10: `mem_rd` and `mem_wr` are never asserted together. `pc_wr` and `pc_wr_cond` are never asserted together.
- R11: Driving `rst_n` low in the middle of an instruction returns the outputs to the fetch pattern at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release expected synchronous to `clk` |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when the ALU reports equal operands |
| addr_sel_data | output | 1 | Memory address from the ALU result register (1) or the PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from the memory data register (1) or the ALU result (0) |
| pc_src | output | 2 | Next-PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 from function field |
| alu_b_sel | output | 2 | ALU B operand: 00 register, 01 constant four, 10 immediate, 11 shifted immediate |
| alu_a_sel | output | 1 | ALU A operand: register (1) or PC (0) |
| reg_wr | output | 1 | Register file write |
| dst_sel_rd | output | 1 | Destination register from the rd field (1) or the rt field (0) |

## Verification
The temporal assertions assume that `opcode` is stable from the end of fetch until the instruction's chain returns to fetch. This holds because the instruction register loads only at the fetch edge. The dispatch made at decode and the one made at address compute must therefore see the same class.

The bench keeps within this assumption. It changes `opcode` only during a fetch cycle and then holds it until the sequencer is back in fetch. The bench sweeps all 64 opcode values in this way, and it also applies a reset in the middle of a load.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OPC_W   = 6;
  localparam int STATE_W = 4;
  localparam int SEL_W   = 2;

  // instruction-class opcodes
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_ALU   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'b000010;

  // ALU operation codes
  localparam logic [SEL_W-1:0] ALU_ADD  = 2'b00;
  localparam logic [SEL_W-1:0] ALU_SUB  = 2'b01;
  localparam logic [SEL_W-1:0] ALU_FUNC = 2'b10;

  // ALU B-operand selects
  localparam logic [SEL_W-1:0] B_REG   = 2'b00;
  localparam logic [SEL_W-1:0] B_FOUR  = 2'b01;
  localparam logic [SEL_W-1:0] B_IMM   = 2'b10;
  localparam logic [SEL_W-1:0] B_BRIMM = 2'b11;

  // next-PC source selects
  localparam logic [SEL_W-1:0] PCS_ALU = 2'b00;
  localparam logic [SEL_W-1:0] PCS_OUT = 2'b01;
  localparam logic [SEL_W-1:0] PCS_JMP = 2'b10;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 0,
    ST_DECODE = 1,
    ST_ADDR   = 2,
    ST_RD     = 3,
    ST_LDWB   = 4,
    ST_WR     = 5,
    ST_EXEC   = 6,
    ST_ALUWB  = 7,
    ST_BRANCH = 8,
    ST_JUMP   = 9
  } state_e;

  typedef enum logic [2:0] {
    CL_LOAD,
    CL_STORE,
    CL_ALU,
    CL_BEQ,
    CL_JMP,
    CL_NONE
  } iclass_e;

  typedef struct packed {
    logic             pc_wr;
    logic             pc_wr_cond;
    logic             addr_data;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_wr;
    logic             wb_mem;
    logic [SEL_W-1:0] pc_src;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] alu_b;
    logic             alu_a;
    logic             reg_wr;
    logic             dst_rd;
  } ctrl_t;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
  import mc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output iclass_e          cls
);

  always_comb begin
    case (opcode)
      OPC_LOAD:  cls = CL_LOAD;
      OPC_STORE: cls = CL_STORE;
      OPC_ALU:   cls = CL_ALU;
      OPC_BEQ:   cls = CL_BEQ;
      OPC_JMP:   cls = CL_JMP;
      default:   cls = CL_NONE;
    endcase
  end

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e  state_q,
  input  iclass_e cls,
  output state_e  state_d
);

  always_comb begin
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CL_LOAD,
          CL_STORE: state_d = ST_ADDR;
          CL_ALU:   state_d = ST_EXEC;
          CL_BEQ:   state_d = ST_BRANCH;
          CL_JMP:   state_d = ST_JUMP;
          default:  state_d = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        if (cls == CL_LOAD)       state_d = ST_RD;
        else if (cls == CL_STORE) state_d = ST_WR;
        else                      state_d = ST_FETCH;
      end
      ST_RD:     state_d = ST_LDWB;
      ST_EXEC:   state_d = ST_ALUWB;
      default:   state_d = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  state_e state_q,
  output ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    case (state_q)
      ST_FETCH: begin
        ctrl.mem_rd = 1'b1;
        ctrl.ir_wr  = 1'b1;
        ctrl.alu_b  = B_FOUR;
        ctrl.alu_op = ALU_ADD;
        ctrl.pc_src = PCS_ALU;
        ctrl.pc_wr  = 1'b1;
      end
      ST_DECODE: begin
        ctrl.alu_b  = B_BRIMM;
        ctrl.alu_op = ALU_ADD;
      end
      ST_ADDR: begin
        ctrl.alu_a  = 1'b1;
        ctrl.alu_b  = B_IMM;
        ctrl.alu_op = ALU_ADD;
      end
      ST_RD: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.addr_data = 1'b1;
      end
      ST_LDWB: begin
        ctrl.reg_wr = 1'b1;
        ctrl.wb_mem = 1'b1;
      end
      ST_WR: begin
        ctrl.mem_wr    = 1'b1;
        ctrl.addr_data = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alu_a  = 1'b1;
        ctrl.alu_b  = B_REG;
        ctrl.alu_op = ALU_FUNC;
      end
      ST_ALUWB: begin
        ctrl.reg_wr = 1'b1;
        ctrl.dst_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alu_a      = 1'b1;
        ctrl.alu_b      = B_REG;
        ctrl.alu_op     = ALU_SUB;
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_src     = PCS_OUT;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_src = PCS_JMP;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
  import mc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             addr_sel_data,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_wr,
  output logic             wb_from_mem,
  output logic [SEL_W-1:0] pc_src,
  output logic [SEL_W-1:0] alu_op,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic             alu_a_sel,
  output logic             reg_wr,
  output logic             dst_sel_rd
);

  state_e  state_q;
  state_e  state_d;
  iclass_e cls;
  ctrl_t   ctrl;

  mc_op_classify u_classify (
    .opcode (opcode),
    .cls    (cls)
  );

  mc_next_state u_next (
    .state_q (state_q),
    .cls     (cls),
    .state_d (state_d)
  );

  mc_ctrl_decode u_decode (
    .state_q (state_q),
    .ctrl    (ctrl)
  );

  // step register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign pc_wr         = ctrl.pc_wr;
  assign pc_wr_cond    = ctrl.pc_wr_cond;
  assign addr_sel_data = ctrl.addr_data;
  assign mem_rd        = ctrl.mem_rd;
  assign mem_wr        = ctrl.mem_wr;
  assign ir_wr         = ctrl.ir_wr;
  assign wb_from_mem   = ctrl.wb_mem;
  assign pc_src        = ctrl.pc_src;
  assign alu_op        = ctrl.alu_op;
  assign alu_b_sel     = ctrl.alu_b;
  assign alu_a_sel     = ctrl.alu_a;
  assign reg_wr        = ctrl.reg_wr;
  assign dst_sel_rd    = ctrl.dst_rd;

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (alu_b_sel == B_BRIMM && !alu_a_sel && !ir_wr)); // R2

  AST_DISPATCH_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE && (opcode == OPC_LOAD || opcode == OPC_STORE))
      |=> (alu_a_sel && alu_b_sel == B_IMM)); // R3

  AST_READ_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_sel_data) |=> (reg_wr && wb_from_mem && !dst_sel_rd)); // R4

  AST_STORE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_wr); // R5

  AST_ALU_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == ALU_FUNC) |=> (reg_wr && dst_sel_rd && !wb_from_mem)); // R6

  AST_BRANCH_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_wr); // R7

  AST_UNKNOWN_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE && cls == CL_NONE) |=> ir_wr); // R9

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

  AST_PC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_wr && pc_wr_cond)); // R10

endmodule

// File: tb/mc_ctrl_seq_tb.sv
`timescale 1ns/1ps
module mc_ctrl_seq_tb;

  logic       clk;
  logic       rst_n;
  logic [5:0] opcode;
  logic       pc_wr, pc_wr_cond, addr_sel_data, mem_rd, mem_wr, ir_wr;
  logic       wb_from_mem, alu_a_sel, reg_wr, dst_sel_rd;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic [16:0] act;

  int checks = 0;
  int errors = 0;

  mc_ctrl_seq u_dut (
    .clk (clk), .rst_n (rst_n), .opcode (opcode),
    .pc_wr (pc_wr), .pc_wr_cond (pc_wr_cond), .addr_sel_data (addr_sel_data),
    .mem_rd (mem_rd), .mem_wr (mem_wr), .ir_wr (ir_wr),
    .wb_from_mem (wb_from_mem), .pc_src (pc_src), .alu_op (alu_op),
    .alu_b_sel (alu_b_sel), .alu_a_sel (alu_a_sel), .reg_wr (reg_wr),
    .dst_sel_rd (dst_sel_rd)
  );

  assign act = {pc_wr, pc_wr_cond, addr_sel_data, mem_rd, mem_wr, ir_wr,
                wb_from_mem, pc_src, alu_op, alu_b_sel, alu_a_sel, reg_wr,
                dst_sel_rd};

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected control vector per step, built field by field
  function automatic logic [16:0] exp_vec(input int st);
    logic pw, pwc, ad, mr, mw, iw, wm, aa, rw, dr;
    logic [1:0] ps, op, bs;
    {pw, pwc, ad, mr, mw, iw, wm, aa, rw, dr} = '0;
    ps = 2'b00; op = 2'b00; bs = 2'b00;
    case (st)
      0: begin mr = 1; iw = 1; pw = 1; bs = 2'b01; end
      1: bs = 2'b11;
      2: begin aa = 1; bs = 2'b10; end
      3: begin mr = 1; ad = 1; end
      4: begin rw = 1; wm = 1; end
      5: begin mw = 1; ad = 1; end
      6: begin aa = 1; op = 2'b10; end
      7: begin rw = 1; dr = 1; end
      8: begin aa = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
      9: begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {pw, pwc, ad, mr, mw, iw, wm, ps, op, bs, aa, rw, dr};
  endfunction

  function automatic int model_next(input int st, input logic [5:0] op);
    case (st)
      0: return 1;
      1: begin
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000000) return 6;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        return 0;
      end
      2: return (op == 6'b100011) ? 3 : 5;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(input logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b101011, 6'b000000: return 4;
      6'b000100, 6'b000010: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string tag_of(input int st);
    case (st)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk_vec(input string req, input logic [16:0] a, input logic [16:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req, a, e);
    end
  endtask

  task automatic chk_int(input string req, input int a, input int e);
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, a, e);
    end
  endtask

  // exclusivity (R10) sampled each step
  task automatic chk_excl();
    chk_int("R10 mem_rd/mem_wr", int'(mem_rd & mem_wr), 0);
    chk_int("R10 pc_wr/pc_wr_cond", int'(pc_wr & pc_wr_cond), 0);
  endtask

  // runs one instruction; called at a negedge inside a fetch cycle
  task automatic run_instr(input logic [5:0] op);
    int st = 0;
    int cyc = 0;
    bit wrote = 0;
    chk_vec("R1 fetch", act, exp_vec(0));
    opcode = op;
    forever begin
      @(posedge clk);
      @(negedge clk);
      st = model_next(st, op);
      cyc++;
      chk_vec(tag_of(st), act, exp_vec(st));
      chk_excl();
      if (st != 0 && (mem_wr || reg_wr)) wrote = 1;
      if (st == 0 || cyc > 8) break;
    end
    case (op)
      6'b100011: chk_int("R4 load length", cyc, exp_len(op));
      6'b101011: chk_int("R5 store length", cyc, exp_len(op));
      6'b000000: chk_int("R6 alu length", cyc, exp_len(op));
      6'b000100: chk_int("R7 branch length", cyc, exp_len(op));
      6'b000010: chk_int("R8 jump length", cyc, exp_len(op));
      default: begin
        chk_int("R9 unknown length", cyc, exp_len(op));
        chk_int("R9 no write", int'(wrote), 0);
      end
    endcase
  endtask

  initial begin
    rst_n  = 1'b0;
    opcode = 6'b111111;
    repeat (3) @(negedge clk);
    chk_vec("R1 in reset", act, exp_vec(0));
    rst_n = 1'b1;
    // first cycle after release is fetch
    run_instr(6'b100011);
    run_instr(6'b101011);
    run_instr(6'b000000);
    run_instr(6'b000100);
    run_instr(6'b000010);
    for (int i = 0; i < 64; i++) run_instr(6'(i));

    // reset in the middle of a load (R11)
    opcode = 6'b100011;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk_vec("R3 mid-load addr", act, exp_vec(2));
    #3 rst_n = 1'b0;
    #1 chk_vec("R11 async return", act, exp_vec(0));
    @(negedge clk);
    chk_vec("R11 held", act, exp_vec(0));
    rst_n = 1'b1;
    run_instr(6'b000000);
    run_instr(6'b100011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule